// File: doc/BRIEF.md
# Masked SIMD Unpack-High Unit

This block is a registered datapath for a vector execution pipe. It takes two 512-bit sources made of 32-bit elements. Each source is split into 128-bit lanes of four elements. Inside each lane, the unit weaves the two upper elements of the first source together with the two upper elements of the second source. No element ever moves across a lane boundary, so a wider vector is built by repeating the same lane pattern over every active lane.

A 2-bit mode picks one of four styles:
- legacy: length fixed at 128 bits, and the bits above it come from the old destination;
- plain three-operand;
- masked with merge;
- masked with zero.

A 2-bit length code picks 128, 256 or 512 bits. The masked styles add a per-element write mask and an optional broadcast of the low 32 bits of the second source.

The result appears one cycle after the input is accepted and is held until the next valid input. The reset input is asynchronous and active low. It is expected to be released synchronously by the reset tree outside the block.

Top module: `unpack_hi_unit`

## Requirements
- R1: Element k occupies bits 32k+31:32k. Within every active 128-bit lane holding elements 4L..4L+3, the result positions are filled as follows: position 4L takes first-source element 4L+2, position 4L+1 takes second-source element 4L+2, position 4L+2 takes first-source element 4L+3, and position 4L+3 takes second-source element 4L+3.
- R2: The length code selects the active element count: 0 gives 4 elements (128 bits), 1 gives 8 (256 bits), and 2 or 3 give 16 (512 bits). In modes 1, 2 and 3, every result element at or above the active count is zero.
- R3: In mode 0 (legacy), the length code is ignored and 4 elements are active. Result bits 511:128 equal old-destination bits 511:128.
- R4: In mode 2 (masked merge), an active element whose mask bit is 0 takes the old-destination element at the same position.
- R5: In mode 3 (masked zero), an active element whose mask bit is 0 becomes zero.
- R6: In modes 2 and 3, an active element whose mask bit is 1 takes the interleaved value. Mask bits at or above the active count have no effect. In modes 0 and 1, the mask is ignored.
- R7: When broadcast is 1 in mode 2 or 3, second-source bits 31:0 stand in for every second-source element. In modes 0 and 1, broadcast has no effect.
- R8: `out_valid` equals `in_valid` from the previous cycle, and `result` carries the value computed from the inputs of that cycle. Reset clears both `out_valid` and `result`.
- R9: In a cycle where `in_valid` is 0, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| mode | input | 2 | 0 legacy, 1 plain, 2 masked merge, 3 masked zero |
| vlen | input | 2 | 0: 128 bits, 1: 256 bits, 2 or 3: 512 bits |
| bcast | input | 1 | Broadcast second-source element 0 (modes 2 and 3) |
| src_a | input | 512 | First source |
| src_b | input | 512 | Second source |
| old_dst | input | 512 | Previous destination value |
| wmask | input | 16 | Per-element write mask |
| out_valid | output | 1 | Result is valid |
| result | output | 512 | Registered result |

## Verification
The bound assertions check the following properties on every cycle:
- the valid pipeline and reset;
- hold of the result while idle;
- clearing of the upper bits for 128-bit non-legacy operations;
- pass-through of the upper bits in legacy mode;
- the rule for element 0 under plain, merge and zero operation.

The full lane pattern across all sixteen positions, the mask bits above the active count, and broadcast under each mode are shown only by the bench's scenarios. Those scenarios compare every result against an independent bench model for random and directed operands.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam logic [1:0] MD_LEGACY = 2'd0;
  localparam logic [1:0] MD_PLAIN  = 2'd1;
  localparam logic [1:0] MD_MERGE  = 2'd2;
  localparam logic [1:0] MD_ZERO   = 2'd3;
  localparam int LANE_ELEMS = 4;
endpackage

// File: rtl/unpk_src_sel.sv
// Second-source selection: optional broadcast of element 0 to every position.
module unpk_src_sel #(
  parameter int EW = 32,
  parameter int NE = 16
) (
  input  logic [NE*EW-1:0] b_in,
  input  logic             bc_en,
  output logic [NE*EW-1:0] b_out
);
  for (genvar e = 0; e < NE; e++) begin : g_el
    assign b_out[e*EW +: EW] = bc_en ? b_in[EW-1:0] : b_in[e*EW +: EW];
  end
endmodule

// File: rtl/unpk_lane.sv
// One lane: interleave the two upper elements of each source.
module unpk_lane #(
  parameter int EW = 32
) (
  input  logic [2*EW-1:0] a_hi,
  input  logic [2*EW-1:0] b_hi,
  output logic [4*EW-1:0] y
);
  assign y = {b_hi[2*EW-1:EW], a_hi[2*EW-1:EW], b_hi[EW-1:0], a_hi[EW-1:0]};
endmodule

// File: rtl/unpk_elem_mask.sv
// Per-element masking, length trimming and legacy pass-through.
module unpk_elem_mask #(
  parameter int EW = 32,
  parameter int NE = 16
) (
  input  logic [NE*EW-1:0] tmp,
  input  logic [NE*EW-1:0] old,
  input  logic [NE-1:0]    kmask,
  input  logic [NE-1:0]    act,
  input  logic [1:0]       mode,
  output logic [NE*EW-1:0] y
);
  import unpk_pkg::*;
  logic masked, zeroing, legacy;
  assign legacy  = (mode == MD_LEGACY);
  assign masked  = (mode == MD_MERGE) || (mode == MD_ZERO);
  assign zeroing = (mode == MD_ZERO);

  for (genvar e = 0; e < NE; e++) begin : g_el
    always_comb begin
      if (!act[e]) begin
        y[e*EW +: EW] = legacy ? old[e*EW +: EW] : '0;
      end else if (masked && !kmask[e]) begin
        y[e*EW +: EW] = zeroing ? '0 : old[e*EW +: EW];
      end else begin
        y[e*EW +: EW] = tmp[e*EW +: EW];
      end
    end
  end
endmodule

// File: rtl/unpack_hi_unit.sv
module unpack_hi_unit #(
  parameter int EW    = 32,
  parameter int VEC_W = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           mode,
  input  logic [1:0]           vlen,
  input  logic                 bcast,
  input  logic [VEC_W-1:0]     src_a,
  input  logic [VEC_W-1:0]     src_b,
  input  logic [VEC_W-1:0]     old_dst,
  input  logic [VEC_W/EW-1:0]  wmask,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     result
);
  import unpk_pkg::*;
  localparam int NE  = VEC_W / EW;
  localparam int EPL = LANE_ELEMS;
  localparam int NL  = NE / EPL;
  localparam int LW  = EPL * EW;
  localparam int CW  = $clog2(NE) + 4;

  logic             bc_en;
  logic [VEC_W-1:0] b_sel, tmp, mixed;
  logic [CW-1:0]    n_act;
  logic [NE-1:0]    act;
  logic [VEC_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;

  assign bc_en = bcast && ((mode == MD_MERGE) || (mode == MD_ZERO));

  unpk_src_sel #(.EW(EW), .NE(NE)) u_sel (
    .b_in(src_b), .bc_en(bc_en), .b_out(b_sel)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lane
    unpk_lane #(.EW(EW)) u_lane (
      .a_hi(src_a[l*LW + 2*EW +: 2*EW]),
      .b_hi(b_sel[l*LW + 2*EW +: 2*EW]),
      .y   (tmp[l*LW +: LW])
    );
  end

  // Active element count from length code, capped at the full vector.
  always_comb begin
    if (mode == MD_LEGACY) begin
      n_act = CW'(EPL);
    end else begin
      n_act = CW'(EPL) << vlen;
      if (n_act > CW'(NE)) n_act = CW'(NE);
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_act
    assign act[e] = (CW'(e) < n_act);
  end

  unpk_elem_mask #(.EW(EW), .NE(NE)) u_mask (
    .tmp(tmp), .old(old_dst), .kmask(wmask), .act(act), .mode(mode), .y(mixed)
  );

  // Next state
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) res_d = mixed;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
endmodule

// File: rtl/unpack_hi_chk.sv
module unpack_hi_chk #(
  parameter int EW    = 32,
  parameter int VEC_W = 512
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          mode,
  input logic [1:0]          vlen,
  input logic [VEC_W-1:0]    src_a,
  input logic [VEC_W-1:0]    old_dst,
  input logic [VEC_W/EW-1:0] wmask,
  input logic                out_valid,
  input logic [VEC_W-1:0]    result
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R9
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'd0 && vlen == 2'd0) |=> (result[VEC_W-1:128] == '0)); // R2
  AST_LEGACY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0) |=> (result[VEC_W-1:128] == $past(old_dst[VEC_W-1:128]))); // R3
  AST_PLAIN_ELEM0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1) |=> (result[EW-1:0] == $past(src_a[3*EW-1:2*EW]))); // R1
  AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && !wmask[0]) |=> (result[EW-1:0] == $past(old_dst[EW-1:0]))); // R4
  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3 && !wmask[0]) |=> (result[EW-1:0] == '0)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && result == '0)); // R8
endmodule

bind unpack_hi_unit unpack_hi_chk #(.EW(EW), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .vlen(vlen),
  .src_a(src_a), .old_dst(old_dst), .wmask(wmask),
  .out_valid(out_valid), .result(result)
);

// File: tb/sim_unpack_hi_unit.sv
module sim_unpack_hi_unit;
  logic         clk, rst_n, in_valid, bcast;
  logic [1:0]   mode, vlen;
  logic [511:0] src_a, src_b, old_dst;
  logic [15:0]  wmask;
  logic         out_valid;
  logic [511:0] result;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  unpack_hi_unit u0 (.*);

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [511:0] model(logic [1:0] md, logic [1:0] vl, logic bc,
      logic [511:0] a, logic [511:0] b, logic [511:0] od, logic [15:0] k);
    logic [511:0] r;
    int n = (md == 0) ? 4 : (vl == 0) ? 4 : (vl == 1) ? 8 : 16;
    for (int e = 0; e < 16; e++) begin
      int src = (e / 4) * 4 + 2 + (e % 4) / 2;
      logic [31:0] bv = (md >= 2 && bc) ? b[31:0] : b[src*32 +: 32];
      logic [31:0] t = (e % 2) ? bv : a[src*32 +: 32];
      if (e >= n) r[e*32 +: 32] = (md == 0) ? od[e*32 +: 32] : 32'd0;
      else if (md >= 2 && !k[e]) r[e*32 +: 32] = (md == 2) ? od[e*32 +: 32] : 32'd0;
      else r[e*32 +: 32] = t;
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] md, logic [1:0] vl, logic bc, logic [511:0] a,
      logic [511:0] b, logic [511:0] od, logic [15:0] k, string req);
    logic [511:0] exp;
    mode = md; vlen = vl; bcast = bc; src_a = a; src_b = b; old_dst = od; wmask = k;
    in_valid = 1;
    exp = model(md, vl, bc, a, b, od, k);
    @(negedge clk);
    check(out_valid === 1'b1, "R8", {511'd0, out_valid}, 512'd1);
    check(result === exp, req, result, exp);
    in_valid = 0;
  endtask

  function automatic string tag_of(logic [1:0] md);
    case (md)
      2'd0: return "R3";
      2'd1: return "R2";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    logic [511:0] a, b, od, held, ident_a, ident_b, exp;
    void'($urandom(32'd1234));
    rst_n = 0; in_valid = 0; mode = 0; vlen = 0; bcast = 0;
    src_a = '0; src_b = '0; old_dst = '0; wmask = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R8", {511'd0, out_valid}, 512'd0);
    check(result === '0, "R8", result, '0);
    rst_n = 1;
    @(negedge clk);

    // R1: element-index patterns
    for (int i = 0; i < 16; i++) begin
      ident_a[i*32 +: 32] = 32'hA000_0000 + i;
      ident_b[i*32 +: 32] = 32'hB000_0000 + i;
    end
    apply(2'd1, 2'd2, 1'b0, ident_a, ident_b, '0, '0, "R1");
    exp = '0;
    for (int l = 0; l < 4; l++) begin
      exp[(4*l)*32 +: 32]   = 32'hA000_0000 + 4*l + 2;
      exp[(4*l+1)*32 +: 32] = 32'hB000_0000 + 4*l + 2;
      exp[(4*l+2)*32 +: 32] = 32'hA000_0000 + 4*l + 3;
      exp[(4*l+3)*32 +: 32] = 32'hB000_0000 + 4*l + 3;
    end
    check(result === exp, "R1", result, exp);

    // R2: lengths, including code 3
    for (int v = 0; v < 4; v++)
      apply(2'd1, v[1:0], 1'b0, rnd512(), rnd512(), rnd512(), 16'hFFFF, "R2");

    // R3: legacy ignores length, mask and broadcast
    apply(2'd0, 2'd2, 1'b1, rnd512(), rnd512(), rnd512(), 16'h0000, "R3");

    // R6: mask bits above the active count ignored
    apply(2'd2, 2'd0, 1'b0, rnd512(), rnd512(), rnd512(), 16'hFFF5, "R6");
    apply(2'd3, 2'd1, 1'b0, rnd512(), rnd512(), rnd512(), 16'hFF3C, "R6");
    apply(2'd1, 2'd2, 1'b0, rnd512(), rnd512(), rnd512(), 16'h0000, "R6");

    // R7: broadcast in masked modes, ignored in plain mode
    apply(2'd2, 2'd2, 1'b1, ident_a, ident_b, rnd512(), 16'hFFFF, "R7");
    apply(2'd3, 2'd1, 1'b1, rnd512(), rnd512(), rnd512(), 16'hA5A5, "R7");
    apply(2'd1, 2'd2, 1'b1, ident_a, ident_b, '0, '0, "R7");

    // R4 / R5 all-zero masks
    apply(2'd2, 2'd2, 1'b0, rnd512(), rnd512(), rnd512(), 16'h0000, "R4");
    apply(2'd3, 2'd2, 1'b0, rnd512(), rnd512(), rnd512(), 16'h0000, "R5");

    // R9: idle cycles hold result even as inputs change
    held = result;
    src_a = rnd512(); src_b = rnd512(); old_dst = rnd512(); mode = 2'd3;
    @(negedge clk);
    check(out_valid === 1'b0, "R8", {511'd0, out_valid}, 512'd0);
    check(result === held, "R9", result, held);
    @(negedge clk);
    check(result === held, "R9", result, held);

    // Random mix
    for (int t = 0; t < 400; t++) begin
      logic [1:0] md = 2'($urandom_range(0, 3));
      a = rnd512(); b = rnd512(); od = rnd512();
      apply(md, 2'($urandom_range(0, 3)), 1'($urandom), a, b, od,
            16'($urandom), tag_of(md));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    // R8: reset mid-stream clears state
    in_valid = 1;
    #3 rst_n = 0;
    #2;
    check(out_valid === 1'b0, "R8", {511'd0, out_valid}, 512'd0);
    check(result === '0, "R8", result, '0);
    in_valid = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule